// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block resolves the source operand of a two-operand add, `Rd <- Rd + operand`, under one of ten addressing modes. A request carries a mode code, three register specifiers (destination `Rd`, base `Rb`, index `Ri`), a constant that serves as displacement, absolute address or immediate, and a two-bit size selector. The block reads the register file, makes zero, one or two reads on a single-ported memory through a valid/ready handshake, updates the base register in the post-increment and post-decrement modes, and writes the sum back to `Rd`.

A controller in the state machine sequences every request. The states are IDLE, ADDR, READ1, READ2, BASEWB, SUMWB and DONE. The transitions are:

- IDLE to ADDR when a start with a legal mode is seen.
- ADDR to SUMWB for the register and immediate modes. ADDR to READ1 for every other mode.
- READ1 to READ2 on ready in the memory-indirect mode. READ1 to BASEWB on ready in the post-increment and post-decrement modes. READ1 to SUMWB on ready in all other modes.
- READ2 to SUMWB on ready.
- BASEWB to SUMWB, SUMWB to DONE, and DONE to IDLE.

While READ1 or READ2 waits for ready, the controller stays in that state. The operand size `d` is `1 << size`, so it is 1, 2, 4 or 8 bytes. Scaling by `d` is done with a shift.

Top module: `opnd_fetch_unit`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `rf_we` are all 0.
- R2: Mode code 0 (register) uses the value of `Rb` as the operand, and mode code 1 (immediate) uses `konst`. Neither mode raises `mem_req`.
- R3: Each of these mode codes makes exactly one memory read, and the value read is the operand. Code 2 (displacement) reads at `konst + Rb`. Code 3 (register indirect) reads at `Rb`. Code 4 (indexed) reads at `Rb + Ri`. Code 5 (absolute) reads at `konst`.
- R4: Code 6 (memory indirect) makes two reads. The first is at `Rb`. The second is at the data returned by the first. The data returned by the second read is the operand.
- R5: Code 7 (post-increment) and code 8 (post-decrement) make one read at the original `Rb`. They then write `Rb + d` or `Rb - d` to `Rb`, where `d = 1 << size` (size 00→1, 01→2, 10→4, 11→8).
- R6: Code 9 (scaled) makes one read at `konst + Rb + (Ri << size)`.
- R7: `Rd` receives the value of `Rd` before the request plus the operand, modulo 2^DW. `result` holds the operand while `done` is high.
- R8: A base update is written in the cycle just before the sum write. When `Rd` equals `Rb`, the final value of that register is the sum.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` stays unchanged. A stalled read still completes correctly.
- R10: A `start` seen while `busy` is high is ignored. A `start` with mode codes 10 to 15 is ignored: `busy` stays low and neither memory nor registers are touched.
- R11: `done` is a one-cycle pulse after the sum write. `busy` is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted only while idle |
| mode | input | 4 | Addressing mode code (0 to 9) |
| rd_sel | input | RAW | Destination register specifier |
| rb_sel | input | RAW | Base register specifier |
| ri_sel | input | RAW | Index register specifier |
| konst | input | DW | Displacement, absolute address or immediate |
| size_sel | input | 2 | Operand size code, d = 1 << size_sel |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DW | Resolved operand |
| rf_rd_addr | output | RAW | Register read port for Rd |
| rf_rd_data | input | DW | Data from the Rd read port |
| rf_rb_addr | output | RAW | Register read port for Rb |
| rf_rb_data | input | DW | Data from the Rb read port |
| rf_ri_addr | output | RAW | Register read port for Ri |
| rf_ri_data | input | DW | Data from the Ri read port |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | RAW | Register write address |
| rf_wdata | output | DW | Register write data |
| mem_req | output | 1 | Memory read valid |
| mem_addr | output | DW | Memory read address |
| mem_ready | input | 1 | Memory accepts the read and returns data |
| mem_rdata | input | DW | Memory read data |

## Verification
The assertions check four things on every cycle:

- A stalled read holds its request and address.
- A base-register write is always followed at once by the sum write.
- The register and immediate modes never reach memory.
- `done` never lasts two cycles, and an illegal mode code never leaves the idle state.

Only the bench scenarios can show the numbers themselves. These are the effective address of each mode, the chained address of the indirect mode, the size-dependent step, the final register contents when destination and base coincide, and the fact that a start during a busy request leaves no trace.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    typedef enum logic [3:0] {
        AM_REG    = 4'd0,
        AM_IMM    = 4'd1,
        AM_DISP   = 4'd2,
        AM_RIND   = 4'd3,
        AM_INDEX  = 4'd4,
        AM_DIRECT = 4'd5,
        AM_MIND   = 4'd6,
        AM_AINC   = 4'd7,
        AM_ADEC   = 4'd8,
        AM_SCALED = 4'd9
    } amode_e;

    localparam int unsigned MODE_LAST = 9;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_READ1  = 3'd2,
        ST_READ2  = 3'd3,
        ST_BASEWB = 3'd4,
        ST_SUMWB  = 3'd5,
        ST_DONE   = 3'd6
    } fstate_e;

    function automatic logic mode_is_legal(input logic [3:0] m);
        return m <= 4'(MODE_LAST);
    endfunction

    function automatic logic mode_has_base_update(input amode_e m);
        return (m == AM_AINC) || (m == AM_ADEC);
    endfunction

endpackage

// File: rtl/opnd_ea_calc.sv
module opnd_ea_calc
    import opnd_pkg::*;
#(
    parameter int DW = 32
) (
    input  amode_e          mode,
    input  logic [DW-1:0]   konst,
    input  logic [DW-1:0]   base,
    input  logic [DW-1:0]   index,
    input  logic [1:0]      size_sel,
    output logic [DW-1:0]   ea,
    output logic [DW-1:0]   direct_opnd,
    output logic [DW-1:0]   step
);

    logic [DW-1:0] scaled_index;

    assign scaled_index = index << size_sel;
    assign step         = DW'(1) << size_sel;
    assign direct_opnd  = (mode == AM_IMM) ? konst : base;

    always_comb begin
        unique case (mode)
            AM_DISP:   ea = konst + base;
            AM_INDEX:  ea = base + index;
            AM_DIRECT: ea = konst;
            AM_SCALED: ea = konst + base + scaled_index;
            AM_RIND, AM_MIND, AM_AINC, AM_ADEC: ea = base;
            default:   ea = '0;
        endcase
    end

endmodule

// File: rtl/opnd_ctrl_fsm.sv
module opnd_ctrl_fsm
    import opnd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic [3:0] mode_in,
    input  amode_e    mode_q,
    input  logic      mem_ready,
    output fstate_e   state,
    output logic      accept,
    output logic      mem_req,
    output logic      base_we,
    output logic      sum_we,
    output logic      done,
    output logic      busy
);

    fstate_e state_nx;

    assign accept = (state == ST_IDLE) && start && mode_is_legal(mode_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_ADDR;
            ST_ADDR:   state_nx = (mode_q == AM_REG || mode_q == AM_IMM) ? ST_SUMWB : ST_READ1;
            ST_READ1: begin
                if (mem_ready) begin
                    if (mode_q == AM_MIND)                  state_nx = ST_READ2;
                    else if (mode_has_base_update(mode_q)) state_nx = ST_BASEWB;
                    else                                    state_nx = ST_SUMWB;
                end
            end
            ST_READ2:  if (mem_ready) state_nx = ST_SUMWB;
            ST_BASEWB: state_nx = ST_SUMWB;
            ST_SUMWB:  state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        base_we = 1'b0;
        sum_we  = 1'b0;
        done    = 1'b0;
        busy    = (state != ST_IDLE);
        unique case (state)
            ST_READ1, ST_READ2: mem_req = 1'b1;
            ST_BASEWB:          base_we = 1'b1;
            ST_SUMWB:           sum_we  = 1'b1;
            ST_DONE:            done    = 1'b1;
            default: ;
        endcase
    end

    AST_BASE_BEFORE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> sum_we); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R11
    AST_ILLEGAL_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !mode_is_legal(mode_in)) |=> !busy); // R10

endmodule

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit
    import opnd_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 8,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3:0]      mode,
    input  logic [RAW-1:0]  rd_sel,
    input  logic [RAW-1:0]  rb_sel,
    input  logic [RAW-1:0]  ri_sel,
    input  logic [DW-1:0]   konst,
    input  logic [1:0]      size_sel,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   result,
    output logic [RAW-1:0]  rf_rd_addr,
    input  logic [DW-1:0]   rf_rd_data,
    output logic [RAW-1:0]  rf_rb_addr,
    input  logic [DW-1:0]   rf_rb_data,
    output logic [RAW-1:0]  rf_ri_addr,
    input  logic [DW-1:0]   rf_ri_data,
    output logic            rf_we,
    output logic [RAW-1:0]  rf_waddr,
    output logic [DW-1:0]   rf_wdata,
    output logic            mem_req,
    output logic [DW-1:0]   mem_addr,
    input  logic            mem_ready,
    input  logic [DW-1:0]   mem_rdata
);

    amode_e         mode_q;
    logic [RAW-1:0] rd_q, rb_q, ri_q;
    logic [DW-1:0]  konst_q;
    logic [1:0]     size_q;
    logic [DW-1:0]  ea_q, opnd_q, rdval_q, base_q;

    fstate_e        state;
    logic           accept, base_we, sum_we;
    logic [DW-1:0]  ea, direct_opnd, step, base_upd;

    opnd_ctrl_fsm u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_in   (mode),
        .mode_q    (mode_q),
        .mem_ready (mem_ready),
        .state     (state),
        .accept    (accept),
        .mem_req   (mem_req),
        .base_we   (base_we),
        .sum_we    (sum_we),
        .done      (done),
        .busy      (busy)
    );

    opnd_ea_calc #(.DW(DW)) u_ea (
        .mode        (mode_q),
        .konst       (konst_q),
        .base        (rf_rb_data),
        .index       (rf_ri_data),
        .size_sel    (size_q),
        .ea          (ea),
        .direct_opnd (direct_opnd),
        .step        (step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= AM_REG;
            rd_q    <= '0;
            rb_q    <= '0;
            ri_q    <= '0;
            konst_q <= '0;
            size_q  <= '0;
            ea_q    <= '0;
            opnd_q  <= '0;
            rdval_q <= '0;
            base_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q  <= amode_e'(mode);
                        rd_q    <= rd_sel;
                        rb_q    <= rb_sel;
                        ri_q    <= ri_sel;
                        konst_q <= konst;
                        size_q  <= size_sel;
                    end
                end
                ST_ADDR: begin
                    rdval_q <= rf_rd_data;
                    base_q  <= rf_rb_data;
                    ea_q    <= ea;
                    if (mode_q == AM_REG || mode_q == AM_IMM) opnd_q <= direct_opnd;
                end
                ST_READ1: begin
                    if (mem_ready) begin
                        if (mode_q == AM_MIND) ea_q   <= mem_rdata;
                        else                   opnd_q <= mem_rdata;
                    end
                end
                ST_READ2: if (mem_ready) opnd_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    assign base_upd   = (mode_q == AM_ADEC) ? (base_q - step) : (base_q + step);

    assign rf_rd_addr = rd_q;
    assign rf_rb_addr = rb_q;
    assign rf_ri_addr = ri_q;
    assign rf_we      = base_we | sum_we;
    assign rf_waddr   = base_we ? rb_q : rd_q;
    assign rf_wdata   = base_we ? base_upd : (rdval_q + opnd_q);
    assign mem_addr   = ea_q;
    assign result     = opnd_q;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R9
    AST_DIRECT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && (mode_q == AM_REG || mode_q == AM_IMM)) |=> !mem_req); // R2

endmodule

// File: tb/opnd_fetch_unit_test.sv
module opnd_fetch_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NREG = 8;
    localparam int RAW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] mode = '0;
    logic [RAW-1:0] rd_sel = '0, rb_sel = '0, ri_sel = '0;
    logic [DW-1:0] konst = '0;
    logic [1:0] size_sel = '0;
    logic busy, done, rf_we, mem_req, mem_ready;
    logic [DW-1:0] result, rf_rd_data, rf_rb_data, rf_ri_data, rf_wdata, mem_addr, mem_rdata;
    logic [RAW-1:0] rf_rd_addr, rf_rb_addr, rf_ri_addr, rf_waddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [DW-1:0] regs [NREG];
    int stall_set = 0, stall_cnt = 0;
    int rcount = 0, wcount = 0, total_reads = 0, total_writes = 0, hold_viol = 0;
    logic [DW-1:0] raddr [4];
    logic [RAW-1:0] waddr_log [4];
    logic stalled_prev = 1'b0;
    logic [DW-1:0] stalled_addr = '0;

    int checks = 0, failures = 0, ops_done = 0;

    function automatic logic [DW-1:0] memval(input logic [DW-1:0] a);
        return (a * 32'h0001_0003) ^ 32'h5A5A_00C3;
    endfunction

    assign rf_rd_data = regs[rf_rd_addr];
    assign rf_rb_data = regs[rf_rb_addr];
    assign rf_ri_data = regs[rf_ri_addr];
    assign mem_ready  = mem_req && (stall_cnt == 0);
    assign mem_rdata  = memval(mem_addr);

    opnd_fetch_unit #(.DW(DW), .NREG(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .rd_sel(rd_sel), .rb_sel(rb_sel), .ri_sel(ri_sel), .konst(konst), .size_sel(size_sel),
        .busy(busy), .done(done), .result(result),
        .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
        .rf_rb_addr(rf_rb_addr), .rf_rb_data(rf_rb_data),
        .rf_ri_addr(rf_ri_addr), .rf_ri_data(rf_ri_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // environment: register file, memory stall model, activity logs
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= 32'h0000_1000 * (i + 1) + 32'h10 * i;
            regs[7] <= 32'hFFFF_FFF8;
        end else begin
            if (start && !busy && mode <= 4'd9) begin
                rcount <= 0;
                wcount <= 0;
                stall_cnt <= stall_set;
            end else begin
                if (mem_req && !mem_ready) stall_cnt <= stall_cnt - 1;
                if (mem_req && mem_ready) begin
                    if (rcount < 4) raddr[rcount] <= mem_addr;
                    rcount <= rcount + 1;
                    total_reads <= total_reads + 1;
                    stall_cnt <= stall_set;
                end
                if (rf_we) begin
                    regs[rf_waddr] <= rf_wdata;
                    if (wcount < 4) waddr_log[wcount] <= rf_waddr;
                    wcount <= wcount + 1;
                    total_writes <= total_writes + 1;
                end
            end
            if (stalled_prev && mem_addr != stalled_addr) hold_viol <= hold_viol + 1;
            stalled_prev <= mem_req && !mem_ready;
            stalled_addr <= mem_addr;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct {
        string         tag;
        logic [DW-1:0] opnd;
        int            nreads;
        logic [DW-1:0] addr1, addr2;
        int            rd, rb;
        logic          upd;
        logic [DW-1:0] rd_final, rb_final;
        int            nwrites;
    } exp_t;

    exp_t sb[$];

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(result == e.opnd, {e.tag, " R7 operand"}, result, e.opnd);
                chk(rcount == e.nreads, {e.tag, " read count"}, DW'(rcount), DW'(e.nreads));
                if (e.nreads >= 1) chk(raddr[0] == e.addr1, {e.tag, " first address"}, raddr[0], e.addr1);
                if (e.nreads >= 2) chk(raddr[1] == e.addr2, {e.tag, " R4 second address"}, raddr[1], e.addr2);
                chk(regs[e.rd] == e.rd_final, {e.tag, " R7 Rd sum"}, regs[e.rd], e.rd_final);
                chk(wcount == e.nwrites, {e.tag, " write count"}, DW'(wcount), DW'(e.nwrites));
                if (e.upd) begin
                    chk(regs[e.rb] == e.rb_final, {e.tag, " R5 base final"}, regs[e.rb], e.rb_final);
                    chk(waddr_log[0] == RAW'(e.rb) && waddr_log[1] == RAW'(e.rd),
                        {e.tag, " R8 base then sum order"},
                        DW'({waddr_log[0], waddr_log[1]}), DW'({RAW'(e.rb), RAW'(e.rd)}));
                end
            end
            ops_done++;
        end
    end

    task automatic issue(input string tag, input logic [3:0] m, input int rd, input int rb, input int ri,
                         input logic [DW-1:0] k, input logic [1:0] sz, input int stall, input logic poke);
        exp_t e;
        logic [DW-1:0] b, x, d, a;
        int target;
        b = regs[rb]; x = regs[ri]; d = DW'(1) << sz; a = '0;
        e.tag = tag; e.rd = rd; e.rb = rb; e.nreads = 0; e.addr1 = '0; e.addr2 = '0;
        e.upd = 1'b0; e.nwrites = 1; e.rb_final = b;
        case (m)
            4'd0: e.opnd = b;
            4'd1: e.opnd = k;
            4'd2: a = k + b;
            4'd4: a = b + x;
            4'd5: a = k;
            4'd9: a = k + b + (x << sz);
            default: a = b;
        endcase
        if (m >= 4'd2) begin
            e.nreads = 1; e.addr1 = a; e.opnd = memval(a);
            if (m == 4'd6) begin
                e.nreads = 2; e.addr2 = memval(a); e.opnd = memval(memval(a));
            end
        end
        if (m == 4'd7 || m == 4'd8) begin
            e.upd = 1'b1; e.nwrites = 2;
            e.rb_final = (m == 4'd7) ? b + d : b - d;
        end
        e.rd_final = regs[rd] + e.opnd;
        if (e.upd && rd == rb) e.rb_final = e.rd_final;
        sb.push_back(e);
        target = ops_done + 1;
        stall_set = stall;
        @(negedge clk);
        start = 1'b1; mode = m; rd_sel = RAW'(rd); rb_sel = RAW'(rb); ri_sel = RAW'(ri);
        konst = k; size_sel = sz;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start = 1'b1; mode = 4'd1; rd_sel = 3'd6; konst = 32'hDEAD_0000;
            @(negedge clk);
            start = 1'b0;
        end
        while (ops_done < target) @(negedge clk);
        @(negedge clk);
        chk(!busy && !done, {tag, " R11 idle after done"}, DW'({busy, done}), 32'd0);
    endtask

    initial begin
        logic [DW-1:0] r6_before;
        int tr, tw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !rf_we, "R1 reset outputs",
            DW'({busy, done, mem_req, rf_we}), 32'd0);

        issue("R2 register", 4'd0, 1, 2, 0, 32'h0, 2'd0, 0, 1'b0);
        issue("R2 immediate", 4'd1, 3, 0, 0, 32'h0000_1234, 2'd0, 0, 1'b0);
        issue("R3 displacement", 4'd2, 1, 3, 0, 32'h0000_0040, 2'd0, 0, 1'b0);
        issue("R3 reg-indirect", 4'd3, 2, 4, 0, 32'h0, 2'd0, 0, 1'b0);
        issue("R3 indexed", 4'd4, 0, 2, 5, 32'h0, 2'd0, 1, 1'b0);
        issue("R3 absolute", 4'd5, 7, 0, 0, 32'h0000_8000, 2'd0, 0, 1'b0);
        issue("R4 mem-indirect", 4'd6, 1, 6, 0, 32'h0, 2'd0, 2, 1'b0);
        issue("R5 postinc size4", 4'd7, 1, 3, 0, 32'h0, 2'd2, 0, 1'b0);
        issue("R5 postdec size8 Rd=Rb", 4'd8, 4, 4, 0, 32'h0, 2'd3, 1, 1'b0);
        issue("R8 postinc size1 Rd=Rb", 4'd7, 5, 5, 0, 32'h0, 2'd0, 0, 1'b0);
        issue("R5 postdec size2", 4'd8, 2, 7, 0, 32'h0, 2'd1, 0, 1'b0);
        issue("R6 scaled size2", 4'd9, 0, 2, 3, 32'h0000_0010, 2'd1, 0, 1'b0);
        issue("R6 scaled size8", 4'd9, 6, 1, 7, 32'h0000_0100, 2'd3, 0, 1'b0);
        issue("R9 stalled displacement", 4'd2, 3, 1, 0, 32'hFFFF_FF00, 2'd0, 4, 1'b0);

        r6_before = regs[6];
        issue("R10 start while busy", 4'd2, 2, 5, 0, 32'h0000_0020, 2'd0, 5, 1'b1);
        chk(regs[6] == r6_before, "R10 busy start left Rd untouched", regs[6], r6_before);

        tr = total_reads; tw = total_writes;
        @(negedge clk);
        start = 1'b1; mode = 4'd12; rd_sel = 3'd1; rb_sel = 3'd2;
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R10 illegal mode keeps idle", DW'(busy), 32'd0);
        repeat (6) @(negedge clk);
        chk(total_reads == tr && total_writes == tw && !done, "R10 illegal mode no activity",
            DW'(total_reads + total_writes), DW'(tr + tw));
        chk(hold_viol == 0, "R9 address held during stall", DW'(hold_viol), 32'd0);
        chk(sb.size() == 0, "R11 no pending completions", DW'(sb.size()), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule